// File: doc/BRIEF.md
# Header Write Lock Guard

This block decides, for every host request to copy the input buffer into a message buffer, whether the header portion of that buffer may be overwritten. While the controller is in either configuration state every header is open. In every other protocol state headers are protected. The protection comes from two sources: membership of the buffer in the receive FIFO, and a 2-bit security-mode field that widens the protected range.

A protected header can still be repaired once, for example after an uncorrectable ECC error. The host writes the two-value key sequence to the lock-key register, which is the same sequence that leaves configuration. If the very next register write is a transfer request, that one transfer is granted whatever the FIFO membership or the security mode. The grant is consumed by the request. Any other write in between withdraws it. The host can read whether a grant is pending.

The block has no data path. It turns register-write strobes, the protocol state and the lock sources into a registered header write enable that travels with the buffer number. The RAM, the ECC logic and the transfer engine act on that enable.

Top module: `hdr_lock_guard`

## Requirements
- R1: During and right after synchronous reset, `hdr_wr_en` and `unlock_armed` are 0.
- R2: When `poc_state` is 0 or 1 (the configuration states), a transfer request for any buffer number below `NUM_BUF` raises `hdr_wr_en` in the cycle after the request, with `hdr_wr_buf` equal to the requested number. A pending one-shot grant changes nothing about this outcome.
- R3: In any other state, with no grant pending, a buffer's header is locked if any of these holds: its `fifo_map` bit is 1; `sec_mode` is 2'b01 and the buffer index is at least `NUM_BUF/2`; `sec_mode[1]` is 1. A locked request gives `hdr_wr_en`=0. An unlocked in-range request gives `hdr_wr_en`=1.
- R4: A lock-key write of 8'hCE followed by a lock-key write of 8'h31 sets `unlock_armed` in the cycle after the second write.
- R5: A lock-key write of any other value, an unrelated register write or a transfer request between the two key writes restarts the sequence. A new 8'hCE starts it again.
- R6: While `unlock_armed` is 1, an in-range transfer request is granted in every state, whatever `fifo_map` and `sec_mode` hold.
- R7: Every transfer request clears `unlock_armed`, so a following request for a locked header is refused.
- R8: An unrelated register write or any lock-key write while armed clears `unlock_armed`.
- R9: A transfer request with a buffer number of `NUM_BUF` or more never raises `hdr_wr_en` and clears `unlock_armed`.
- R10: Cycles with no register write neither advance nor reset the key sequence detector, and they do not clear `unlock_armed`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_wr | input | 1 | Host write strobe to the lock-key register |
| key_data | input | 8 | Value written to the lock-key register |
| xfer_req | input | 1 | Host write strobe to the input-buffer transfer request register |
| xfer_buf | input | BUF_W | Target message buffer number of the transfer |
| other_wr | input | 1 | Strobe for any other register write |
| poc_state | input | 3 | Protocol state code (0 and 1 are configuration states) |
| fifo_map | input | NUM_BUF | Per-buffer FIFO membership |
| sec_mode | input | 2 | Security-mode lock field |
| hdr_wr_en | output | 1 | Registered header write enable for the requested transfer |
| hdr_wr_buf | output | BUF_W | Buffer number that goes with `hdr_wr_en` |
| unlock_armed | output | 1 | One-shot header unlock is pending |

## Verification
A wrong internal state shows up in one of two places. A stuck or stale sequence detector appears on `unlock_armed` one cycle after the second key write. A grant that lingers or was never set appears on `hdr_wr_en` in the cycle after the next transfer request. The bench sweeps every protocol state, every security mode, several FIFO maps and every buffer number, including out-of-range ones, with and without a pending grant. This way a wrong lock decision or a missing consumption is caught on the very next request. Directed sequences with interrupted keys, idle gaps and disarming writes then check the detector's memory.

// File: rtl/hdr_lock_pkg.sv
package hdr_lock_pkg;
  localparam logic [7:0] KEY_FIRST  = 8'hCE;
  localparam logic [7:0] KEY_SECOND = 8'h31;

  localparam logic [2:0] ST_DEFAULT_CFG = 3'd0;
  localparam logic [2:0] ST_CFG         = 3'd1;

  localparam logic [1:0] SEC_FIFO_ONLY  = 2'b00;
  localparam logic [1:0] SEC_UPPER_HALF = 2'b01;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_HALF = 1'b1
  } key_seq_t;

  function automatic logic is_cfg_state(input logic [2:0] st);
    return (st == ST_DEFAULT_CFG) || (st == ST_CFG);
  endfunction
endpackage

// File: rtl/hdr_key_seq.sv
module hdr_key_seq
  import hdr_lock_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       key_wr,
  input  logic [7:0] key_data,
  input  logic       xfer_req,
  input  logic       other_wr,
  output logic       armed
);
  key_seq_t seq_q, seq_d;
  logic     armed_d;
  logic     any_wr;

  assign any_wr = key_wr | xfer_req | other_wr;

  always_comb begin
    seq_d   = seq_q;
    armed_d = armed;
    if (any_wr) begin
      armed_d = 1'b0;
      seq_d   = SEQ_IDLE;
      if (key_wr) begin
        if (seq_q == SEQ_HALF && key_data == KEY_SECOND) begin
          armed_d = 1'b1;
        end else if (key_data == KEY_FIRST) begin
          seq_d = SEQ_HALF;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_q <= SEQ_IDLE;
      armed <= 1'b0;
    end else begin
      seq_q <= seq_d;
      armed <= armed_d;
    end
  end
endmodule

// File: rtl/hdr_lock_map.sv
module hdr_lock_map
  import hdr_lock_pkg::*;
#(
  parameter int NUM_BUF = 16,
  parameter int BUF_W   = 5
) (
  input  logic [NUM_BUF-1:0] fifo_map,
  input  logic [1:0]         sec_mode,
  input  logic [BUF_W-1:0]   sel_buf,
  output logic               sel_locked,
  output logic               sel_in_range
);
  localparam int            HALF      = NUM_BUF / 2;
  localparam logic [BUF_W:0] NUM_BUF_W = (BUF_W + 1)'(NUM_BUF);

  logic [NUM_BUF-1:0] lock_vec;

  for (genvar gi = 0; gi < NUM_BUF; gi++) begin : g_lock
    if (gi >= HALF) begin : g_upper
      assign lock_vec[gi] = fifo_map[gi] | sec_mode[1] | (sec_mode == SEC_UPPER_HALF);
    end else begin : g_lower
      assign lock_vec[gi] = fifo_map[gi] | sec_mode[1];
    end
  end

  assign sel_in_range = ({1'b0, sel_buf} < NUM_BUF_W);

  always_comb begin
    sel_locked = 1'b1;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (sel_buf == BUF_W'(i)) sel_locked = lock_vec[i];
    end
  end
endmodule

// File: rtl/hdr_wr_gate.sv
module hdr_wr_gate
  import hdr_lock_pkg::*;
#(
  parameter int BUF_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xfer_req,
  input  logic [BUF_W-1:0] xfer_buf,
  input  logic [2:0]       poc_state,
  input  logic             sel_locked,
  input  logic             sel_in_range,
  input  logic             armed,
  output logic             hdr_wr_en,
  output logic [BUF_W-1:0] hdr_wr_buf
);
  logic grant;

  assign grant = xfer_req & sel_in_range &
                 (is_cfg_state(poc_state) | armed | ~sel_locked);

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_wr_en  <= 1'b0;
      hdr_wr_buf <= '0;
    end else begin
      hdr_wr_en <= grant;
      if (xfer_req) hdr_wr_buf <= xfer_buf;
    end
  end
endmodule

// File: rtl/hdr_lock_guard.sv
module hdr_lock_guard
  import hdr_lock_pkg::*;
#(
  parameter int NUM_BUF = 16,
  parameter int BUF_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               key_wr,
  input  logic [7:0]         key_data,
  input  logic               xfer_req,
  input  logic [BUF_W-1:0]   xfer_buf,
  input  logic               other_wr,
  input  logic [2:0]         poc_state,
  input  logic [NUM_BUF-1:0] fifo_map,
  input  logic [1:0]         sec_mode,
  output logic               hdr_wr_en,
  output logic [BUF_W-1:0]   hdr_wr_buf,
  output logic               unlock_armed
);
  logic sel_locked;
  logic sel_in_range;

  hdr_key_seq u_key_seq (
    .clk      (clk),
    .rst      (rst),
    .key_wr   (key_wr),
    .key_data (key_data),
    .xfer_req (xfer_req),
    .other_wr (other_wr),
    .armed    (unlock_armed)
  );

  hdr_lock_map #(.NUM_BUF(NUM_BUF), .BUF_W(BUF_W)) u_lock_map (
    .fifo_map     (fifo_map),
    .sec_mode     (sec_mode),
    .sel_buf      (xfer_buf),
    .sel_locked   (sel_locked),
    .sel_in_range (sel_in_range)
  );

  hdr_wr_gate #(.BUF_W(BUF_W)) u_wr_gate (
    .clk          (clk),
    .rst          (rst),
    .xfer_req     (xfer_req),
    .xfer_buf     (xfer_buf),
    .poc_state    (poc_state),
    .sel_locked   (sel_locked),
    .sel_in_range (sel_in_range),
    .armed        (unlock_armed),
    .hdr_wr_en    (hdr_wr_en),
    .hdr_wr_buf   (hdr_wr_buf)
  );
endmodule

// File: rtl/hdr_lock_guard_chk.sv
module hdr_lock_guard_chk
  import hdr_lock_pkg::*;
#(
  parameter int NUM_BUF = 16,
  parameter int BUF_W   = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             key_wr,
  input logic [7:0]       key_data,
  input logic             xfer_req,
  input logic [BUF_W-1:0] xfer_buf,
  input logic             other_wr,
  input logic [2:0]       poc_state,
  input logic [1:0]       sec_mode,
  input logic             hdr_wr_en,
  input logic [BUF_W-1:0] hdr_wr_buf,
  input logic             unlock_armed
);
  localparam logic [BUF_W:0] NB = (BUF_W + 1)'(NUM_BUF);

  logic req_in_range;
  logic cfg_now;
  assign req_in_range = ({1'b0, xfer_buf} < NB);
  assign cfg_now      = (poc_state == ST_DEFAULT_CFG) || (poc_state == ST_CFG);

  p_en_needs_req_r2: assert property (@(posedge clk) disable iff (rst)
    hdr_wr_en |-> $past(xfer_req));

  p_en_buf_tracks_r2: assert property (@(posedge clk) disable iff (rst)
    hdr_wr_en |-> hdr_wr_buf == $past(xfer_buf));

  p_cfg_open_r2: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && cfg_now && req_in_range) |=> hdr_wr_en);

  p_sec_all_locked_r3: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && !cfg_now && !unlock_armed && sec_mode[1]) |=> !hdr_wr_en);

  p_arm_from_key_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(unlock_armed) |-> $past(key_wr && key_data == KEY_SECOND));

  p_armed_grant_r6: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && unlock_armed && req_in_range) |=> hdr_wr_en);

  p_single_use_r7: assert property (@(posedge clk) disable iff (rst)
    xfer_req |=> !unlock_armed);

  p_other_disarms_r8: assert property (@(posedge clk) disable iff (rst)
    other_wr |=> !unlock_armed);

  p_range_r9: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && !req_in_range) |=> !hdr_wr_en);

  p_idle_holds_r10: assert property (@(posedge clk) disable iff (rst)
    (!key_wr && !xfer_req && !other_wr) |=> $stable(unlock_armed));
endmodule

bind hdr_lock_guard hdr_lock_guard_chk #(.NUM_BUF(NUM_BUF), .BUF_W(BUF_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .key_wr       (key_wr),
  .key_data     (key_data),
  .xfer_req     (xfer_req),
  .xfer_buf     (xfer_buf),
  .other_wr     (other_wr),
  .poc_state    (poc_state),
  .sec_mode     (sec_mode),
  .hdr_wr_en    (hdr_wr_en),
  .hdr_wr_buf   (hdr_wr_buf),
  .unlock_armed (unlock_armed)
);

// File: tb/hdr_lock_guard_tb.sv
module hdr_lock_guard_tb;
  localparam int NB = 6;
  localparam int BW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          key_wr = 1'b0;
  logic [7:0]    key_data = 8'h00;
  logic          xfer_req = 1'b0;
  logic [BW-1:0] xfer_buf = '0;
  logic          other_wr = 1'b0;
  logic [2:0]    poc_state = 3'd0;
  logic [NB-1:0] fifo_map = '0;
  logic [1:0]    sec_mode = 2'b00;
  logic          hdr_wr_en;
  logic [BW-1:0] hdr_wr_buf;
  logic          unlock_armed;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hdr_lock_guard #(.NUM_BUF(NB), .BUF_W(BW)) u_dut (
    .clk(clk), .rst(rst), .key_wr(key_wr), .key_data(key_data),
    .xfer_req(xfer_req), .xfer_buf(xfer_buf), .other_wr(other_wr),
    .poc_state(poc_state), .fifo_map(fifo_map), .sec_mode(sec_mode),
    .hdr_wr_en(hdr_wr_en), .hdr_wr_buf(hdr_wr_buf), .unlock_armed(unlock_armed)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic key(input logic [7:0] v);
    @(negedge clk); key_wr = 1'b1; key_data = v;
    @(negedge clk); key_wr = 1'b0;
  endtask

  task automatic other();
    @(negedge clk); other_wr = 1'b1;
    @(negedge clk); other_wr = 1'b0;
  endtask

  task automatic xfer(input int b);
    @(negedge clk); xfer_req = 1'b1; xfer_buf = BW'(b);
    @(negedge clk); xfer_req = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int exp_lock(input int b, input logic [1:0] s, input logic [NB-1:0] f);
    return (f[b] || s[1] || (s == 2'b01 && b >= NB / 2)) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [NB-1:0] maps [3];
    maps[0] = 6'b000000;
    maps[1] = 6'b101001;
    maps[2] = 6'b111111;

    idle(3);
    chk("R1 en in reset", int'(hdr_wr_en), 0);
    chk("R1 armed in reset", int'(unlock_armed), 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 en after reset", int'(hdr_wr_en), 0);
    chk("R1 armed after reset", int'(unlock_armed), 0);

    // Sweep: state x sec x map x buffer x armed
    for (int st = 0; st < 5; st++) begin
      for (int s = 0; s < 4; s++) begin
        for (int m = 0; m < 3; m++) begin
          for (int b = 0; b < 8; b++) begin
            for (int a = 0; a < 2; a++) begin
              int e;
              string tag;
              poc_state = 3'(st);
              sec_mode  = 2'(s);
              fifo_map  = maps[m];
              if (a == 1) begin
                key(8'hCE);
                key(8'h31);
                chk("R4 armed after key pair", int'(unlock_armed), 1);
              end
              xfer(b);
              if (b >= NB) begin
                e = 0; tag = "R9 out of range";
              end else if (st < 2) begin
                e = 1; tag = "R2 config open";
              end else if (a == 1) begin
                e = 1; tag = "R6 armed override";
              end else begin
                e = 1 - exp_lock(b, 2'(s), maps[m]); tag = "R3 lock rule";
              end
              chk(tag, int'(hdr_wr_en), e);
              if (e == 1) chk("R2 buffer number", int'(hdr_wr_buf), b);
              chk("R7 consumed", int'(unlock_armed), 0);
            end
          end
        end
      end
    end

    // Directed: locked setting for the rest
    poc_state = 3'd3; sec_mode = 2'b10; fifo_map = '0;

    key(8'hCE); key(8'h55); key(8'h31);
    chk("R5 wrong value restarts", int'(unlock_armed), 0);
    key(8'hCE); other(); key(8'h31);
    chk("R5 other write restarts", int'(unlock_armed), 0);
    key(8'hCE); xfer(NB); key(8'h31);
    chk("R5 xfer restarts", int'(unlock_armed), 0);
    key(8'hCE); key(8'hCE); key(8'h31);
    chk("R5 CE restarts sequence", int'(unlock_armed), 1);
    other();
    chk("R8 other write disarms", int'(unlock_armed), 0);
    xfer(1);
    chk("R8 locked after disarm", int'(hdr_wr_en), 0);

    key(8'hCE); idle(5); key(8'h31);
    chk("R10 gap in sequence", int'(unlock_armed), 1);
    idle(5);
    chk("R10 gap keeps armed", int'(unlock_armed), 1);
    xfer(2);
    chk("R6 grant after gap", int'(hdr_wr_en), 1);
    xfer(2);
    chk("R7 second xfer refused", int'(hdr_wr_en), 0);

    key(8'hCE); key(8'h31); key(8'h00);
    chk("R8 key write disarms", int'(unlock_armed), 0);
    xfer(0);
    chk("R8 refused after key write", int'(hdr_wr_en), 0);

    key(8'hCE); key(8'h31); xfer(7);
    chk("R9 out of range refused", int'(hdr_wr_en), 0);
    chk("R9 out of range disarms", int'(unlock_armed), 0);
    xfer(0);
    chk("R9 next locked refused", int'(hdr_wr_en), 0);

    sec_mode = 2'b00; fifo_map = 6'b000001;
    xfer(1);
    chk("R3 unlocked non-FIFO", int'(hdr_wr_en), 1);
    xfer(0);
    chk("R3 FIFO buffer locked", int'(hdr_wr_en), 0);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule